// File: doc/BRIEF.md
# Dual Wiper Position Serial Receiver

This block is the digital front end of a dual 256-position resistor-string potentiometer. A host writes wiper positions over a write-only three-wire serial link made of an active-low select, a shift clock and a data line. Bits are captured while select is low. When select rises, the most recent ten captured bits form a frame. The frame holds a two-bit channel address and an eight-bit position code, and it is applied to channel A, channel B, or both channels.

Each channel keeps its position in an eight-bit register that sits in the system clock domain. The register also drives a one-hot tap-select vector with one line per switch of the resistor string. A power-on reset parks both wipers at midscale. The commit event crosses from the serial domain through a synchronizer, so a new position reaches the outputs a few system clocks after select rises.

Top module: `dual_wiper_spi`

## Requirements
- R1: While rstN is low, and after it is released with no frame written since, posA and posB both read 8'h80 and tapA and tapB each have only bit 128 set.
- R2: sdi is sampled on each rising edge of sclk while csN is low. The first bit sent becomes address bit 1, the second becomes address bit 0, and the next eight bits become the position code, most significant bit first.
- R3: A frame whose address is 2'b00 loads its code into channel A only. A frame whose address is 2'b01 loads its code into channel B only. The channel that is not addressed keeps its value.
- R4: A frame whose address is 2'b11 loads the same code into both channels.
- R5: A frame whose address is 2'b10 changes neither channel.
- R6: A frame with fewer than ten rising sclk edges between the fall and the rise of csN changes neither channel.
- R7: A frame with more than ten rising sclk edges is decoded from its last ten bits only. The earlier bits are discarded.
- R8: The outputs do not change while csN is low. A committed frame shows on the outputs no later than the fourth rising clk edge after csN rises. The outputs still show the old values after the first rising clk edge that follows that csN rise.
- R9: At all times tapA and tapB each have exactly one bit set, at the index equal to the channel code. Bit 0 is the tap at the low end of the string and bit 255 is the tap at the high end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the position registers |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| csN | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial shift clock, rising-edge sampled |
| sdi | input | 1 | Serial data in |
| posA | output | 8 | Channel A position code |
| posB | output | 8 | Channel B position code |
| tapA | output | 256 | Channel A one-hot tap select |
| tapB | output | 256 | Channel B one-hot tap select |

## Verification
The assertions assume that csN stays high for several system clock periods after each rising edge, and that a frame lasts much longer than the synchronizer latency. Under that assumption a commit strobe is a single-cycle pulse that always falls while select is still high. The stimulus keeps csN high for more than 100 ns between frames, which is 25 clocks at 250 MHz. It also runs sclk at about 20 MHz, so each frame spans many system clocks and the captured frame never changes while it is being committed.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  parameter int unsigned POS_W  = 8;
  parameter int unsigned ADDR_W = 2;

  typedef struct packed {
    logic             loadA;
    logic             loadB;
    logic [POS_W-1:0] code;
  } wiperStrobe_t;
endpackage

// File: rtl/wiper_serial_ctrl.sv
module wiper_serial_ctrl
  import wiper_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sclk,
  input  logic         sdi,
  output wiperStrobe_t strobes
);
  localparam int unsigned FRAME_BITS = ADDR_W + POS_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] shiftReg, frameHold;
  logic [CNT_W-1:0]      bitCnt;
  logic                  holdFull;
  logic [SYNC_STAGES:0]  csPipe;
  logic                  commit;
  logic [ADDR_W-1:0]     addr;

  // Serial domain: cleared while select is high, shifts on sclk otherwise.
  always_ff @(posedge sclk or posedge csN) begin
    if (csN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], sdi};
      if (bitCnt != FULL_CNT) bitCnt <= bitCnt + 1'b1;
    end
  end

  // Snapshot taken on the select rising edge; stays static until the next frame ends.
  always_ff @(posedge csN) begin
    frameHold <= shiftReg;
    holdFull  <= (bitCnt == FULL_CNT);
  end

  // Select crosses into the system domain; its rising edge is the commit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csPipe <= '1;
    else       csPipe <= {csPipe[SYNC_STAGES-1:0], csN};
  end

  assign commit = csPipe[SYNC_STAGES-1] & ~csPipe[SYNC_STAGES];
  assign addr   = frameHold[FRAME_BITS-1 -: ADDR_W];

  always_comb begin
    strobes.code  = frameHold[POS_W-1:0];
    strobes.loadA = commit & holdFull & (addr == 2'b00 || addr == 2'b11);
    strobes.loadB = commit & holdFull & (addr == 2'b01 || addr == 2'b11);
  end
endmodule

// File: rtl/wiper_datapath.sv
module wiper_datapath
  import wiper_pkg::*;
#(
  parameter int unsigned CHANNELS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  wiperStrobe_t       strobes,
  output logic [POS_W-1:0]   posA,
  output logic [POS_W-1:0]   posB,
  output logic [(1<<POS_W)-1:0] tapA,
  output logic [(1<<POS_W)-1:0] tapB
);
  localparam int unsigned TAPS = 1 << POS_W;
  localparam logic [POS_W-1:0] MID_CODE = POS_W'(1) << (POS_W - 1);

  logic [POS_W-1:0] pos  [CHANNELS];
  logic [TAPS-1:0]  taps [CHANNELS];

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : gChan
    logic load;
    assign load = (ch == 0) ? strobes.loadA : strobes.loadB;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     pos[ch] <= MID_CODE;
      else if (load) pos[ch] <= strobes.code;
    end

    for (genvar t = 0; t < TAPS; t++) begin : gTap
      assign taps[ch][t] = (pos[ch] == POS_W'(t));
    end
  end

  assign posA = pos[0];
  assign posB = pos[1];
  assign tapA = taps[0];
  assign tapB = taps[1];
endmodule

// File: rtl/dual_wiper_spi.sv
module dual_wiper_spi
  import wiper_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csN,
  input  logic                  sclk,
  input  logic                  sdi,
  output logic [POS_W-1:0]      posA,
  output logic [POS_W-1:0]      posB,
  output logic [(1<<POS_W)-1:0] tapA,
  output logic [(1<<POS_W)-1:0] tapB
);
  wiperStrobe_t ctlStrobes;

  wiper_serial_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .strobes(ctlStrobes)
  );

  wiper_datapath #(.CHANNELS(2)) uData (
    .clk(clk), .rstN(rstN), .strobes(ctlStrobes),
    .posA(posA), .posB(posB), .tapA(tapA), .tapB(tapB)
  );
endmodule

// File: rtl/wiper_checker.sv
module wiper_checker
  import wiper_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  csN,
  input wiperStrobe_t          strobes,
  input logic [POS_W-1:0]      posA,
  input logic [POS_W-1:0]      posB,
  input logic [(1<<POS_W)-1:0] tapA,
  input logic [(1<<POS_W)-1:0] tapB
);
  AST_TAP_ONEHOT_A: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapA) == 1); // R9
  AST_TAP_ONEHOT_B: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapB) == 1); // R9
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadA |=> $stable(posA)); // R3
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadB |=> $stable(posB)); // R3
  AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadA && strobes.loadB) |=> (posA == posB)); // R4
  AST_COMMIT_SELECT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadA || strobes.loadB) |-> csN); // R8
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadA || strobes.loadB) |=> !(strobes.loadA || strobes.loadB)); // R8
endmodule

bind dual_wiper_spi wiper_checker uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .strobes(ctlStrobes),
  .posA(posA), .posB(posB), .tapA(tapA), .tapB(tapB)
);

// File: tb/tb_dual_wiper_spi.sv
module tb_dual_wiper_spi;
  localparam time CLK_HALF = 2ns;
  localparam time SCK_HALF = 24ns;
  localparam time CS_GAP   = 120ns;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [7:0]   posA, posB;
  logic [255:0] tapA, tapB;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] modelA = 8'h80, modelB = 8'h80;

  dual_wiper_spi dut (.clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
                      .posA(posA), .posB(posB), .tapA(tapA), .tapB(tapB));

  always #CLK_HALF clk = ~clk;

  task automatic checkState(input string req, input logic [7:0] eA, input logic [7:0] eB);
    logic [255:0] tA, tB;
    tA = 256'd1 << eA;
    tB = 256'd1 << eB;
    checks++;
    if (posA !== eA || posB !== eB || tapA !== tA || tapB !== tB) begin
      fails++;
      $display("FAIL %s: posA=%h posB=%h tapA_ok=%0b tapB_ok=%0b expected posA=%h posB=%h",
               req, posA, posB, tapA === tA, tapB === tB, eA, eB);
    end
  endtask

  // Shift n bits (MSB of the n-bit field first), apply the model, then settle.
  task automatic sendBits(input logic [15:0] bits, input int n, input string req);
    logic [9:0] w;
    #CS_GAP;
    csN = 1'b0;
    #SCK_HALF;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      #SCK_HALF; sclk = 1'b1;
      #SCK_HALF; sclk = 1'b0;
    end
    @(negedge clk);
    checkState({req, " R8 no change while selected"}, modelA, modelB);
    #SCK_HALF;
    csN = 1'b1;
    @(negedge clk);
    checkState({req, " R8 old value one clock after select rise"}, modelA, modelB);
    if (n >= 10) begin
      w = bits[9:0];
      case (w[9:8])
        2'b00: modelA = w[7:0];
        2'b01: modelB = w[7:0];
        2'b11: begin modelA = w[7:0]; modelB = w[7:0]; end
        default: ;
      endcase
    end
    repeat (4) @(negedge clk);
    checkState(req, modelA, modelB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkState("R1 in reset", 8'h80, 8'h80);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkState("R1 after reset", 8'h80, 8'h80);

    for (int c = 0; c < 256; c++) sendBits({6'd0, 2'b00, 8'(c)}, 10, "R2 R3 R9 sweep A");
    for (int c = 0; c < 256; c++) sendBits({6'd0, 2'b01, 8'(255 - c)}, 10, "R2 R3 R9 sweep B");

    sendBits({6'd0, 2'b11, 8'h5A}, 10, "R4 both");
    sendBits({6'd0, 2'b11, 8'hFF}, 10, "R4 both full");
    sendBits({6'd0, 2'b10, 8'h33}, 10, "R5 no-op address");
    sendBits({6'd0, 2'b10, 8'h00}, 10, "R5 no-op address zero");
    sendBits({7'd0, 9'h0C3}, 9, "R6 nine bits");
    sendBits(16'h0000, 0, "R6 empty frame");
    sendBits({6'd0, 2'b11, 8'h00}, 10, "R4 both zero");
    sendBits({3'b111, 3'b000, 2'b00, 8'h3C}, 13, "R7 thirteen bits to A");
    sendBits({6'b110101, 2'b01, 8'hC7}, 16, "R7 sixteen bits to B");
    sendBits({6'b000000, 2'b10, 8'h11}, 16, "R7 R5 long no-op");

    rstN = 1'b0;
    modelA = 8'h80; modelB = 8'h80;
    @(negedge clk);
    checkState("R1 reset mid run", 8'h80, 8'h80);
    rstN = 1'b1;
    sendBits({6'd0, 2'b00, 8'h01}, 10, "R1 R3 after second reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule